// File: doc/BRIEF.md
# Tick-Timed Line Deglitcher

This block cleans up a slow single-wire bus input before a protocol engine sees it. The raw pin is asynchronous to the system clock, so it is first brought into the clock domain. A free-running prescaler then produces a periodic tick. The tick period comes from one of four fixed bases: a short base of a few clocks, 1 µs, 10 µs or 100 µs. The filtered output moves to a new level only after the synchronized input has disagreed with it for more than `delay × 3` consecutive ticks. Any shorter excursion is dropped, and the output keeps its previous level.

The block has no data stream, so there is no valid/ready handshake. All pins are plain control or level signals. In the usual setting the 1 µs base is used with a delay of 7. That setting discards disturbances up to about 21 µs. A delay of 0 switches filtering off. A synchronous software reset and an enable give the surrounding logic direct control. The idle bus level is high, and the output returns to high on either reset.

Top module: `glf_line_filter`

## Requirements
- R1: While `rst_n` is low, and in every cycle that follows a cycle with `soft_rst` high, `line_out` is 1, whatever `line_in` does.
- R2: With `delay` = 0, `line_out` equals `line_in` delayed by exactly three clock edges, single-cycle pulses included.
- R3: `tick_sel` picks the tick period T in clocks: 0 gives BASE_DIV (3), 1 gives CLKS_PER_US (24), 2 gives 10×CLKS_PER_US and 3 gives 100×CLKS_PER_US. With `delay` nonzero, `line_out` changes only in the cycle after a tick.
- R4: With `delay` = D > 0, an excursion of `line_in` away from `line_out` that lasts at most 3·D·T clocks leaves `line_out` unchanged.
- R5: With `delay` = D > 0, a new level held for at least (3·D+1)·T clocks appears on `line_out`. It appears between 3·D·T+3 and (3·D+1)·T+2 clock edges after the input change.
- R6: A return of the synchronized input to the `line_out` level, even for one cycle, discards all accumulated tick progress. Repeated short excursions therefore never add up to an accepted change.
- R7: While `enable` is low, the prescaler and the stability count are held cleared and `line_out` keeps its level. After `enable` rises, filtering resumes normally.
- R8: With `tick_sel` = 1 and `delay` = 7, a 21 µs (504-clock) pulse is rejected and a level held 22 µs or longer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset; holds the filter idle while high |
| enable | input | 1 | Runs the prescaler and stability counter when high |
| tick_sel | input | 2 | Tick time-base select (0: base, 1: 1 µs, 2: 10 µs, 3: 100 µs) |
| delay | input | 3 | Stability threshold in units of three ticks; 0 bypasses filtering |
| line_in | input | 1 | Raw asynchronous bus line |
| line_out | output | 1 | Deglitched bus line, idle high |

## Verification
In a single cycle, the tick that would complete the threshold can arrive at the same edge where the synchronized input falls back to the output level. The design lets the match win: the count clears and the output does not flip. The bench provokes this by sweeping the pulse width one clock at a time across the threshold with the shortest tick base, so every phase of the free-running prescaler meets the pulse end. Each width is judged against the R4 and R5 bounds: widths up to 3·D·T must never move the output, and widths of (3·D+1)·T or more must always move it.

// File: rtl/glf_pkg.sv
package glf_pkg;
  localparam int DELAY_W  = 3;
  localparam int TAP_MULT = 3;
  localparam int THR_MAX  = ((1 << DELAY_W) - 1) * TAP_MULT;
  localparam int CNT_W    = $clog2(THR_MAX + 1);
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    TB_BASE  = 2'd0,
    TB_1US   = 2'd1,
    TB_10US  = 2'd2,
    TB_100US = 2'd3
  } tick_sel_e;
endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain <= {STAGES{IDLE}};
    else if (soft_rst) chain <= {STAGES{IDLE}};
    else               chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/glf_tick_gen.sv
module glf_tick_gen
  import glf_pkg::*;
#(
  parameter int BASE_DIV    = 3,
  parameter int CLKS_PER_US = 24,
  parameter int DECADES     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int BASE_W = $clog2(BASE_DIV);
  localparam int US_W   = $clog2(CLKS_PER_US);
  localparam int NTICK  = DECADES + 2;

  logic [BASE_W-1:0] base_cnt;
  logic [US_W-1:0]   us_cnt;
  logic [NTICK-1:0]  ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   base_cnt <= '0;
    else if (clr) base_cnt <= '0;
    else if (base_cnt == BASE_W'(BASE_DIV - 1)) base_cnt <= '0;
    else          base_cnt <= base_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   us_cnt <= '0;
    else if (clr) us_cnt <= '0;
    else if (us_cnt == US_W'(CLKS_PER_US - 1)) us_cnt <= '0;
    else          us_cnt <= us_cnt + 1'b1;
  end

  assign ticks[0] = (base_cnt == BASE_W'(BASE_DIV - 1));
  assign ticks[1] = (us_cnt == US_W'(CLKS_PER_US - 1));

  for (genvar g = 0; g < DECADES; g++) begin : g_decade
    logic [3:0] dcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dcnt <= '0;
      else if (clr) dcnt <= '0;
      else if (ticks[g+1]) dcnt <= (dcnt == 4'd9) ? 4'd0 : dcnt + 4'd1;
    end
    assign ticks[g+2] = ticks[g+1] && (dcnt == 4'd9);
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NTICK; i++)
      if (int'(sel) == i) tick = ticks[i];
  end
endmodule

// File: rtl/glf_stab.sv
module glf_stab
  import glf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               enable,
  input  logic               tick,
  input  logic [DELAY_W-1:0] delay,
  input  logic               sync_in,
  output logic               line_out,
  output logic [CNT_W-1:0]   cnt
);
  logic [CNT_W-1:0] thr;
  assign thr = CNT_W'(delay) * CNT_W'(TAP_MULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_out <= 1'b1;
      cnt      <= '0;
    end else if (soft_rst) begin
      line_out <= 1'b1;
      cnt      <= '0;
    end else if (!enable) begin
      cnt <= '0;
    end else if (delay == '0) begin
      line_out <= sync_in;
      cnt      <= '0;
    end else if (sync_in == line_out) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= thr) begin
        line_out <= sync_in;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/glf_line_filter.sv
module glf_line_filter
  import glf_pkg::*;
#(
  parameter int BASE_DIV    = 3,
  parameter int CLKS_PER_US = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               enable,
  input  logic [SEL_W-1:0]   tick_sel,
  input  logic [DELAY_W-1:0] delay,
  input  logic               line_in,
  output logic               line_out
);
  logic             sync_q;
  logic             tick;
  logic [CNT_W-1:0] stab_cnt;

  glf_sync #(.STAGES(2), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .d(line_in), .q(sync_q)
  );

  glf_tick_gen #(
    .BASE_DIV(BASE_DIV), .CLKS_PER_US(CLKS_PER_US), .DECADES(2)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst || !enable),
    .sel(tick_sel), .tick(tick)
  );

  glf_stab u_stab (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
    .tick(tick), .delay(delay), .sync_in(sync_q),
    .line_out(line_out), .cnt(stab_cnt)
  );
endmodule

// File: rtl/glf_line_filter_chk.sv
module glf_line_filter_chk
  import glf_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic               enable,
  input logic [DELAY_W-1:0] delay,
  input logic               sync_q,
  input logic               tick,
  input logic               line_out,
  input logic [CNT_W-1:0]   cnt
);
  a_r1_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> line_out);

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !soft_rst && delay == '0) |=> (line_out == $past(sync_q)));

  a_r3_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !soft_rst && delay != '0 && !tick) |=> $stable(line_out));

  a_r4_flip_toward_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_out) && !$past(soft_rst)) |-> (line_out == $past(sync_q)));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !soft_rst && delay != '0 && sync_q == line_out) |=> (cnt == '0));

  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !soft_rst) |=> ($stable(line_out) && cnt == '0));
endmodule

bind glf_line_filter glf_line_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
  .delay(delay), .sync_q(sync_q), .tick(tick), .line_out(line_out),
  .cnt(stab_cnt)
);

// File: tb/tb_glf_line_filter.sv
`timescale 1ns/1ps
module tb_glf_line_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       enable = 1'b1;
  logic [1:0] tick_sel = 2'd0;
  logic [2:0] delay = 3'd0;
  logic       line_in = 1'b1;
  logic       line_out;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  glf_line_filter dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
    .tick_sel(tick_sel), .delay(delay), .line_in(line_in), .line_out(line_out)
  );

  function automatic int tper(input int sel);
    case (sel)
      0: return 3;
      1: return 24;
      2: return 240;
      default: return 2400;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts cycles in which line_out differs from lvl
  task automatic watch(input int n, input logic lvl, output int dev);
    dev = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (line_out !== lvl) dev++;
    end
  endtask

  task automatic pulse(input int len, input logic lvl);
    line_in = lvl;
    for (int i = 0; i < len; i++) @(posedge clk);
    @(negedge clk);
    line_in = ~lvl;
  endtask

  task automatic latency(input logic lvl, input int lim, output int k);
    line_in = lvl;
    k = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (line_out === lvl) break;
    end
  endtask

  task automatic do_soft_rst();
    soft_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    int dev;
    chk(line_out === 1'b1, "R1 reset level", line_out, 1);
    line_in = 1'b0;
    soft_rst = 1'b1;
    delay = 3'd0;
    watch(40, 1'b1, dev);
    chk(dev == 0, "R1 soft_rst holds idle", dev, 0);
    soft_rst = 1'b0;
    watch(6, 1'b0, dev);
    chk(line_out === 1'b0, "R1 release follows input", line_out, 0);
    line_in = 1'b1;
    watch(6, 1'b1, dev);
  endtask

  task automatic t_bypass();
    logic [4:0] seen;
    delay = 3'd0;
    line_in = 1'b0;
    @(posedge clk); @(negedge clk);
    seen[0] = line_out;
    line_in = 1'b1;
    for (int i = 1; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      seen[i] = line_out;
    end
    chk(seen == 5'b11011, "R2 bypass 3-edge latency", int'(seen), int'(5'b11011));
  endtask

  task automatic t_filter(input int sel, input int dly, input string req);
    int n, t, dev, k;
    n = dly * 3;
    t = tper(sel);
    tick_sel = 2'(sel);
    delay = 3'(dly);
    do_soft_rst();
    pulse(n * t, 1'b0);
    watch((n + 1) * t + 10, 1'b1, dev);
    chk(dev == 0, {req, " R4 reject pulse"}, dev, 0);
    latency(1'b0, (n + 2) * t + 10, k);
    chk(k >= n * t + 3 && k <= (n + 1) * t + 2, {req, " R5 accept latency"},
        k, (n + 1) * t + 2);
    latency(1'b1, (n + 2) * t + 10, k);
    chk(line_out === 1'b1, {req, " R5 return to idle"}, line_out, 1);
  endtask

  task automatic t_restart();
    int dev;
    tick_sel = 2'd0;
    delay = 3'd1;
    do_soft_rst();
    dev = 0;
    for (int r = 0; r < 6; r++) begin
      int d1;
      pulse(8, 1'b0);
      watch(1, 1'b1, d1);
      dev += d1;
    end
    begin
      int d2;
      watch(20, 1'b1, d2);
      dev += d2;
    end
    chk(dev == 0, "R6 short excursions do not accumulate", dev, 0);
  endtask

  task automatic t_enable();
    int dev, k;
    tick_sel = 2'd0;
    delay = 3'd1;
    do_soft_rst();
    enable = 1'b0;
    line_in = 1'b0;
    watch(200, 1'b1, dev);
    chk(dev == 0, "R7 disabled output holds", dev, 0);
    enable = 1'b1;
    latency(1'b0, 40, k);
    chk(line_out === 1'b0 && k <= 14, "R7 resumes after enable", k, 14);
    latency(1'b1, 40, k);
  endtask

  task automatic t_sweep();
    int dev;
    tick_sel = 2'd0;
    delay = 3'd1;
    for (int len = 1; len <= 15; len++) begin
      do_soft_rst();
      pulse(len, 1'b0);
      watch(30, 1'b1, dev);
      if (len <= 9)
        chk(dev == 0, "R4 sweep rejected width", len, 0);
      else if (len >= 12)
        chk(dev > 0, "R5 sweep accepted width", len, 1);
    end
    do_soft_rst();
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_filter(0, 1, "R3 sel0");
    t_filter(1, 7, "R8 sel1 d7");
    t_filter(2, 1, "R3 sel2");
    t_filter(3, 1, "R3 sel3");
    t_restart();
    t_enable();
    t_sweep();
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule